// File: doc/BRIEF.md
# Pulse-Rate Rectifying Neuron

This block is a clocked digital model of a neuron whose values are carried as pulse rates. A value is the average rate of one-cycle-high strobes on a wire. Two streams arrive: an excitatory stream on `in_pulse` and an inhibitory stream on `cancel_pulse`. Over a long window, the block emits strobes on `out_pulse` at the excitatory rate minus the inhibitory rate when that difference is positive, and emits nothing when it is not. The result is a rectified-linear transfer.

It contains no counters and no arithmetic. A one-bit cancel store remembers at most one pending inhibitory strobe. A second one-bit store, the main store, is armed by every excitatory strobe and is read by a copy of that strobe delayed `DELAY` cycles. An excitatory strobe that finds a cancel pending consumes the cancel and clears the main store in the same cycle, so its delayed read finds nothing. When excitatory strobes come closer together than the read delay, the main store is re-armed before it is read. The block then forwards every input, and this limits the highest usable input rate.

Top module: `pulse_relu_neuron`

## Requirements
- R1: A synchronous reset empties both stores and the read delay line. `out_pulse` is low in the cycle after reset is sampled, a cancel taken before reset kills no later input, and an input taken in the cycle before reset produces no output.
- R2: With no cancel pending and no other input within `DELAY` cycles, an input strobe taken in cycle N gives exactly one output strobe, high in cycle N+`DELAY`. `out_pulse` is never high unless a delayed read is present in that cycle.
- R3: An input strobe taken while a cancel is pending produces no output and empties the cancel store, so the next input again produces an output.
- R4: The cancel store holds at most one cancel. A second cancel strobe taken while one is pending is discarded, and a pending cancel stays pending until an input reads it.
- R5: When an input strobe and a cancel strobe arrive in the same cycle, the input reads the cancel store before the cancel is written. The input is therefore not killed by that cancel, and the cancel stays pending for the next input.
- R6: For periodic streams with input period greater than `DELAY`, the number of output strobes over a window equals the positive part of (input count minus cancel count), to within one.
- R7: When the input period is shorter than `DELAY` and no cancels arrive, the main store stays armed across reads, and the output count equals the input count to within one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_pulse | input | 1 | Excitatory strobe, one cycle high per pulse |
| cancel_pulse | input | 1 | Inhibitory strobe, one cycle high per pulse |
| out_pulse | output | 1 | Output strobe, high for one cycle per emitted pulse |

## Verification
The hardest situation to reach is the one where the main store is still armed by a later input when an earlier input's delayed read arrives. This only happens when the input spacing falls below the read delay. The bench reaches it by driving an input stream with a period of two cycles against the default delay of three, with the per-pulse scoreboard switched off. It then compares counts, because in that regime the output strobes no longer belong to particular inputs. The same-cycle ordering and the discarded second cancel are reached with short directed sequences. Each of these is timed so that its effect shows up as a present or missing output strobe on a later input.

// File: rtl/prn_pkg.sv
package prn_pkg;

  typedef enum logic {
    ST_EMPTY = 1'b0,
    ST_HELD  = 1'b1
  } store_e;

  // One-bit pulse store update: the read acts on the present state,
  // then a write arms the store unless a clear accompanies it.
  function automatic store_e store_step(store_e cur, logic rd, logic wr, logic clr);
    store_e nxt;
    if (wr && !clr)     nxt = ST_HELD;
    else if (wr && clr) nxt = ST_EMPTY;
    else if (rd)        nxt = ST_EMPTY;
    else                nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/prn_cancel_store.sv
module prn_cancel_store
  import prn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic rd,
  output logic held,
  output logic fire
);
  store_e st;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_EMPTY;
    else     st <= store_step(st, rd, wr, 1'b0);
  end

  assign held = (st == ST_HELD);
  assign fire = rd & held;
endmodule

// File: rtl/prn_main_store.sv
module prn_main_store
  import prn_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic rd,
  output logic held,
  output logic fire
);
  store_e st;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_EMPTY;
    else     st <= store_step(st, rd, set, clr);
  end

  assign held = (st == ST_HELD);
  assign fire = rd & held;
endmodule

// File: rtl/prn_read_delay.sv
module prn_read_delay #(
  parameter int unsigned DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic strobe_out
);
  generate
    if (DELAY == 1) begin : g_one
      logic tap;
      always_ff @(posedge clk) begin
        if (rst) tap <= 1'b0;
        else     tap <= strobe_in;
      end
      assign strobe_out = tap;
    end else begin : g_chain
      logic [DELAY-1:0] taps;
      always_ff @(posedge clk) begin
        if (rst) taps <= '0;
        else     taps <= {taps[DELAY-2:0], strobe_in};
      end
      assign strobe_out = taps[DELAY-1];
    end
  endgenerate
endmodule

// File: rtl/pulse_relu_neuron.sv
module pulse_relu_neuron #(
  parameter int unsigned DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_pulse,
  input  logic cancel_pulse,
  output logic out_pulse
);
  logic cancel_held;
  logic kill_strobe;
  logic read_strobe;
  logic main_held;

  prn_cancel_store u_cancel (
    .clk  (clk),
    .rst  (rst),
    .wr   (cancel_pulse),
    .rd   (in_pulse),
    .held (cancel_held),
    .fire (kill_strobe)
  );

  prn_read_delay #(.DELAY(DELAY)) u_delay (
    .clk        (clk),
    .rst        (rst),
    .strobe_in  (in_pulse),
    .strobe_out (read_strobe)
  );

  prn_main_store u_main (
    .clk  (clk),
    .rst  (rst),
    .set  (in_pulse),
    .clr  (kill_strobe),
    .rd   (read_strobe),
    .held (main_held),
    .fire (out_pulse)
  );
endmodule

// File: rtl/pulse_relu_neuron_chk.sv
module pulse_relu_neuron_chk (
  input logic clk,
  input logic rst,
  input logic in_pulse,
  input logic cancel_pulse,
  input logic out_pulse,
  input logic cancel_held,
  input logic main_held,
  input logic kill_strobe,
  input logic read_strobe
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_pulse && !cancel_held && !main_held));

  a_r2_out_on_read: assert property (@(posedge clk) disable iff (rst)
    out_pulse |-> read_strobe);

  a_r3_kill_needs_cancel: assert property (@(posedge clk) disable iff (rst)
    kill_strobe |-> (cancel_held && in_pulse));

  a_r3_kill_disarms: assert property (@(posedge clk) disable iff (rst)
    kill_strobe |=> !main_held);

  a_r4_cancel_persists: assert property (@(posedge clk) disable iff (rst)
    (cancel_held && !in_pulse) |=> cancel_held);

  a_r5_same_cycle_pending: assert property (@(posedge clk) disable iff (rst)
    (in_pulse && cancel_pulse) |=> cancel_held);

  a_r7_rearm_holds: assert property (@(posedge clk) disable iff (rst)
    (in_pulse && !kill_strobe) |=> main_held);
endmodule

bind pulse_relu_neuron pulse_relu_neuron_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_pulse     (in_pulse),
  .cancel_pulse (cancel_pulse),
  .out_pulse    (out_pulse),
  .cancel_held  (cancel_held),
  .main_held    (main_held),
  .kill_strobe  (kill_strobe),
  .read_strobe  (read_strobe)
);

// File: tb/pulse_relu_neuron_tb.sv
module pulse_relu_neuron_tb;
  localparam int DELAY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_p = 1'b0;
  logic can_p = 1'b0;
  logic out_p;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int outs = 0;
  int q[$];
  bit sb_on = 1'b1;
  bit pend = 1'b0;
  bit exp_now;
  string cur_req = "R2";

  pulse_relu_neuron #(.DELAY(DELAY)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .in_pulse     (in_p),
    .cancel_pulse (can_p),
    .out_pulse    (out_p)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // Monitor: pops expected output cycles and compares them with out_pulse.
  always @(negedge clk) begin
    if (!rst) begin
      exp_now = sb_on && (q.size() > 0) && (q[0] == cyc);
      if (exp_now) void'(q.pop_front());
      if (sb_on && (exp_now || out_p)) begin
        total++;
        if (out_p !== exp_now) begin
          bad++;
          $display("FAIL %s scoreboard cycle %0d: out=%0b expected=%0b", cur_req, cyc, out_p, exp_now);
        end
      end
      if (out_p) outs++;
    end
  end

  task automatic chk(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic chk_near(string req, int act, int expv);
    total++;
    if (act > expv + 1 || act < expv - 1) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (+/-1)", req, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected output cycle.
  task automatic step(bit i, bit c);
    @(negedge clk);
    in_p = i;
    can_p = c;
    if (i) begin
      if (!pend && sb_on) q.push_back(cyc + DELAY);
      pend = c;
    end else if (c) begin
      pend = 1'b1;
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_p = 1'b0;
    can_p = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q.delete();
    pend = 1'b0;
    outs = 0;
  endtask

  task automatic run_rate(int pi, int pc, string req, bit fast);
    int nin;
    int ncan;
    int expv;
    do_reset();
    cur_req = req;
    nin = 0;
    ncan = 0;
    for (int k = 0; k < 600; k++) begin
      bit i;
      bit c;
      i = (k % pi == 0);
      c = (pc > 0) && (k % pc == 1);
      if (i) nin++;
      if (c) ncan++;
      step(i, c);
    end
    idle(DELAY + 3);
    if (fast) expv = nin;
    else expv = (nin > ncan) ? nin - ncan : 0;
    chk_near(req, outs, expv);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    cur_req = "R1";
    chk("R1 out low after reset", int'(out_p), 0);

    // R2: lone input gives one strobe DELAY cycles later (scoreboard times it)
    cur_req = "R2";
    step(1'b1, 1'b0);
    idle(6);
    chk("R2 single input", outs, 1);

    // R3: pending cancel kills next input, then is consumed
    cur_req = "R3";
    outs = 0;
    step(1'b0, 1'b1);
    idle(1);
    step(1'b1, 1'b0);
    idle(6);
    chk("R3 killed input", outs, 0);
    step(1'b1, 1'b0);
    idle(6);
    chk("R3 cancel consumed", outs, 1);

    // R4: second cancel while one pending is discarded
    cur_req = "R4";
    outs = 0;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    idle(1);
    step(1'b1, 1'b0);
    idle(5);
    step(1'b1, 1'b0);
    idle(6);
    chk("R4 one cancel held", outs, 1);

    // R5: same-cycle cancel affects only the next input
    cur_req = "R5";
    outs = 0;
    step(1'b1, 1'b1);
    idle(5);
    chk("R5 same-cycle input passes", outs, 1);
    step(1'b1, 1'b0);
    idle(6);
    chk("R5 next input killed", outs, 1);

    // R1: reset drops pending cancel and an in-flight input
    cur_req = "R1";
    step(1'b0, 1'b1);
    do_reset();
    step(1'b1, 1'b0);
    idle(6);
    chk("R1 cancel cleared by reset", outs, 1);
    step(1'b1, 1'b0);
    do_reset();
    idle(6);
    chk("R1 in-flight input dropped", outs, 0);

    // R6: rate transfer for several period pairs
    run_rate(5, 10, "R6 in5 can10", 1'b0);
    run_rate(4, 6,  "R6 in4 can6",  1'b0);
    run_rate(6, 4,  "R6 in6 can4",  1'b0);
    run_rate(7, 7,  "R6 in7 can7",  1'b0);
    run_rate(5, 0,  "R6 in5 nocan", 1'b0);
    chk("R2 scoreboard drained", q.size(), 0);

    // R7: inputs faster than the read delay are all forwarded
    sb_on = 1'b0;
    run_rate(2, 0, "R7 too fast", 1'b1);
    sb_on = 1'b1;

    summary();
    $finish;
  end
endmodule